// File: doc/BRIEF.md
# Masked SIMD Lane Execution Unit

This block is an eight-lane integer vector datapath driven by one shared instruction stream. Each cycle a single decoded operation (add, multiply, multiply-accumulate or move) is broadcast to every lane. Each lane applies it to its own pair of 32-bit operands and keeps the result in its own accumulator register. A per-lane write mask decides which lanes are allowed to commit.

Data-dependent control flow is handled without letting lanes fetch on their own. A branch command compares the operands in every lane and narrows the mask to the lanes where the test is true, so the then-side runs only there. An else command flips to the complementary lanes under the same parent. An end command restores the parent mask, and at reconvergence every lane commits again. The parent masks live in a small stack, so branches can be nested. A population count of the live mask shows how many lanes do useful work in each cycle. An overflowing or underflowing stack sets a sticky error flag.

Top module: `simd_mask_unit`

## Requirements
- R1: When `op_valid` is high, every lane whose mask bit is set loads the result of the broadcast operation on its own operands into its accumulator, visible on `lane_res` one cycle later, and `commit_pulse` is high for that one cycle.
- R2: A lane whose mask bit is clear during an issued operation keeps its accumulator unchanged.
- R3: The branch command (`br_ctl` = 1) computes per lane the bit (signed `opnd_a` > signed `opnd_b`), pushes the current mask, and makes the new mask the old mask AND those bits. It never sets a lane that was clear.
- R4: The else command (`br_ctl` = 2) replaces the mask with (stack top AND NOT current mask). The end command (`br_ctl` = 3) pops the stack and restores the stored mask.
- R5: The stack holds four parent masks, so four nested branches are accepted without error.
- R6: An operation issued while the mask is all zeros changes no lane, gives `skip_pulse` high and `commit_pulse` low in the following cycle.
- R7: `active_cnt` equals the number of set bits in `lane_mask` in every cycle: it is 1 in the single-lane case and 8 after full reconvergence.
- R8: A branch command with four entries stacked, or an else or end command with an empty stack, leaves the mask and stack unchanged and sets `nest_err`. The flag stays set until reset.
- R9: After reset all accumulators are 0, `lane_mask` is all ones, `active_cnt` is 8, and `nest_err`, `commit_pulse` and `skip_pulse` are 0.
- R10: An operation and a branch command in the same cycle use the same operands. The operation commits under the mask that was in force before that command.
- R11: Opcodes are 0 = a+b, 1 = a*b, 2 = accumulator + a*b, 3 = a. All are modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue the broadcast operation this cycle |
| op_code | input | 2 | Operation select (R11 encoding) |
| br_ctl | input | 2 | 0 none, 1 branch, 2 else, 3 end |
| opnd_a | input | 256 | Lane operands A, lane i at bits [32i+31:32i] |
| opnd_b | input | 256 | Lane operands B, same packing |
| lane_res | output | 256 | Lane accumulators, same packing |
| commit_pulse | output | 1 | Previous issue committed in at least one lane |
| skip_pulse | output | 1 | Previous issue found an empty mask |
| lane_mask | output | 8 | Current write mask, bit i for lane i |
| active_cnt | output | 4 | Number of set mask bits |
| nest_err | output | 1 | Sticky mask stack misuse flag |

## Verification
An arithmetic commit and a mask change can happen in the same clock, because the operands feed both the lanes and the branch comparison. The bench issues a multiply-accumulate together with a branch command, and a move together with an else command. In both cases it expects the write to follow the mask that was in force before the command, while the mask seen on the next cycle already reflects the command. A reference model in the bench applies the operation first and the mask update second. The scoreboard compares the accumulators, the mask, the count and the pulses after each of these edges.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_MUL = 2'd1,
    OP_MAC = 2'd2,
    OP_MOV = 2'd3
  } lane_op_e;

  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_IF   = 2'd1,
    BR_ELSE = 2'd2,
    BR_END  = 2'd3
  } br_ctl_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  logic         wr_en,
  input  logic [1:0]   opc,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] acc,
  output logic         cond
);
  import simd_pkg::*;

  logic [W-1:0] prod;
  logic [W-1:0] nxt;

  assign prod = a * b;
  assign cond = $signed(a) > $signed(b);

  always_comb begin
    unique case (lane_op_e'(opc))
      OP_ADD:  nxt = a + b;
      OP_MUL:  nxt = prod;
      OP_MAC:  nxt = acc + prod;
      default: nxt = a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                 acc <= '0;
    else if (issue && wr_en) acc <= nxt;
  end
endmodule

// File: rtl/mask_stack.sv
module mask_stack #(
  parameter int LANES = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ctl,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] mask_q,
  output logic             err_q
);
  import simd_pkg::*;

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LANES-1:0] mem [DEPTH];
  logic [SP_W-1:0]  sp_q;
  logic [LANES-1:0] top;
  logic             full, empty, push;

  assign full  = (sp_q == SP_W'(DEPTH));
  assign empty = (sp_q == '0);
  assign top   = mem[IDX_W'(sp_q - 1'b1)];
  assign push  = (br_ctl_e'(ctl) == BR_IF) && !full;

  // storage has no reset so it can map onto a RAM
  always_ff @(posedge clk) begin
    if (push) mem[IDX_W'(sp_q)] <= mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      sp_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (br_ctl_e'(ctl))
        BR_IF: begin
          if (full) err_q <= 1'b1;
          else begin
            mask_q <= mask_q & cond;
            sp_q   <= sp_q + 1'b1;
          end
        end
        BR_ELSE: begin
          if (empty) err_q <= 1'b1;
          else       mask_q <= top & ~mask_q;
        end
        BR_END: begin
          if (empty) err_q <= 1'b1;
          else begin
            mask_q <= top;
            sp_q   <= sp_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lane_popcount.sv
module lane_popcount #(
  parameter int N = 8,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CW'(bits[i]);
  end
endmodule

// File: rtl/simd_mask_unit.sv
module simd_mask_unit #(
  parameter int LANES = 8,
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int VW   = LANES * W,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [1:0]       op_code,
  input  logic [1:0]       br_ctl,
  input  logic [VW-1:0]    opnd_a,
  input  logic [VW-1:0]    opnd_b,
  output logic [VW-1:0]    lane_res,
  output logic             commit_pulse,
  output logic             skip_pulse,
  output logic [LANES-1:0] lane_mask,
  output logic [CW-1:0]    active_cnt,
  output logic             nest_err
);
  logic [LANES-1:0] cond_vec;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_lane #(.W(W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .issue(op_valid),
      .wr_en(lane_mask[g]),
      .opc  (op_code),
      .a    (opnd_a[g*W +: W]),
      .b    (opnd_b[g*W +: W]),
      .acc  (lane_res[g*W +: W]),
      .cond (cond_vec[g])
    );
  end

  mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .ctl   (br_ctl),
    .cond  (cond_vec),
    .mask_q(lane_mask),
    .err_q (nest_err)
  );

  lane_popcount #(.N(LANES)) u_pop (
    .bits (lane_mask),
    .count(active_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_pulse <= 1'b0;
      skip_pulse   <= 1'b0;
    end else begin
      commit_pulse <= op_valid && (|lane_mask);
      skip_pulse   <= op_valid && !(|lane_mask);
    end
  end
endmodule

// File: rtl/simd_mask_chk.sv
module simd_mask_chk #(
  parameter int LANES = 8,
  parameter int W     = 32,
  localparam int VW   = LANES * W,
  localparam int CW   = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [1:0]       br_ctl,
  input logic [VW-1:0]    lane_res,
  input logic             commit_pulse,
  input logic             skip_pulse,
  input logic [LANES-1:0] lane_mask,
  input logic [CW-1:0]    active_cnt,
  input logic             nest_err
);
  for (genvar g = 0; g < LANES; g++) begin : g_hold
    // R2
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !lane_mask[g]) |=> $stable(lane_res[g*W +: W]));
  end

  // R6
  empty_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && lane_mask == '0) |=> (skip_pulse && !commit_pulse && $stable(lane_res)));

  // R7
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    active_cnt == CW'($countones(lane_mask)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    nest_err |=> nest_err);

  // R3
  branch_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (br_ctl == 2'd1) |=> ((lane_mask & ~$past(lane_mask)) == '0));

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lane_mask == '1 && !nest_err && !commit_pulse && !skip_pulse));

  // R10
  same_cycle_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && br_ctl != 2'd0 && lane_mask != '0) |=> commit_pulse);
endmodule

bind simd_mask_unit simd_mask_chk #(.LANES(LANES), .W(W)) u_chk (.*);

// File: tb/tb_simd_mask_unit.sv
`timescale 1ns/1ps
module tb_simd_mask_unit;
  localparam int L = 8;
  localparam int W = 32;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst;
  logic op_valid;
  logic [1:0] op_code, br_ctl;
  logic [L*W-1:0] opnd_a, opnd_b, lane_res;
  logic commit_pulse, skip_pulse, nest_err;
  logic [L-1:0] lane_mask;
  logic [3:0] active_cnt;

  always #4 clk = ~clk;

  simd_mask_unit dut (.*);

  typedef struct packed {
    logic [L*W-1:0] res;
    logic [L-1:0]   mask;
    logic [3:0]     cnt;
    logic           val;
    logic           skp;
    logic           err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] m_acc [L];
  logic [L-1:0] m_mask;
  logic [L-1:0] m_stk[$];
  logic         m_err;

  task automatic chk(input string tag, input string what, input logic [L*W-1:0] act, input logic [L*W-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [L*W-1:0] pack_acc();
    logic [L*W-1:0] v;
    for (int i = 0; i < L; i++) v[i*W +: W] = m_acc[i];
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < L; i++) m_acc[i] = '0;
    m_mask = '1;
    m_stk.delete();
    m_err = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0; br_ctl = 2'd0; op_code = 2'd0;
    opnd_a = '0; opnd_b = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // driver: drives one cycle of stimulus and queues the expected state
  task automatic issue(input string tag, input logic [1:0] ctl, input bit v, input logic [1:0] opc,
                       input int ab, input int as, input int bb, input int bs);
    logic [W-1:0] a [L];
    logic [W-1:0] b [L];
    logic [L-1:0] cnd;
    logic [L-1:0] m;
    exp_t e;
    @(negedge clk);
    for (int i = 0; i < L; i++) begin
      a[i] = W'(ab + i * as);
      b[i] = W'(bb + i * bs);
      opnd_a[i*W +: W] = a[i];
      opnd_b[i*W +: W] = b[i];
      cnd[i] = $signed(a[i]) > $signed(b[i]);
    end
    op_valid = v; op_code = opc; br_ctl = ctl;
    m = m_mask;
    if (v) begin
      for (int i = 0; i < L; i++) begin
        if (m[i]) begin
          case (opc)
            2'd0: m_acc[i] = a[i] + b[i];
            2'd1: m_acc[i] = a[i] * b[i];
            2'd2: m_acc[i] = m_acc[i] + a[i] * b[i];
            default: m_acc[i] = a[i];
          endcase
        end
      end
    end
    case (ctl)
      2'd1: if (m_stk.size() == D) m_err = 1'b1;
            else begin m_stk.push_back(m_mask); m_mask = m_mask & cnd; end
      2'd2: if (m_stk.size() == 0) m_err = 1'b1;
            else m_mask = m_stk[m_stk.size()-1] & ~m_mask;
      2'd3: if (m_stk.size() == 0) m_err = 1'b1;
            else m_mask = m_stk.pop_back();
      default: ;
    endcase
    e.res  = pack_acc();
    e.mask = m_mask;
    e.cnt  = 4'($countones(m_mask));
    e.val  = v && (m != '0);
    e.skp  = v && (m == '0);
    e.err  = m_err;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0; br_ctl = 2'd0;
    @(negedge clk);
  endtask

  // monitor: compares one expected item per edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "lane_res", lane_res, e.res);
      chk(t, "mask/cnt", {lane_mask, active_cnt}, {e.mask, e.cnt});
      chk(t, "commit/skip/err", {commit_pulse, skip_pulse, nest_err}, {e.val, e.skp, e.err});
    end
  end

  initial begin
    rst = 1'b1;
    do_reset();
    @(negedge clk);
    // R9 reset state
    chk("R9", "lane_res", lane_res, '0);
    chk("R9", "mask/cnt/err/pulses", {lane_mask, active_cnt, nest_err, commit_pulse, skip_pulse},
        {8'hFF, 4'd8, 1'b0, 1'b0, 1'b0});

    issue("R1",  2'd0, 1, 2'd0, 10, 3, 100, 7);
    issue("R11", 2'd0, 1, 2'd1, -5, 2, 6, -1);
    issue("R10", 2'd1, 1, 2'd2, -3, 1, 0, 0);     // lanes 4..7 true, MAC under full mask
    issue("R2",  2'd0, 1, 2'd0, 1000, 1, 1, 1);   // then-side only
    issue("R4",  2'd2, 1, 2'd3, 7, 7, 0, 0);      // move under then mask, flip to else
    issue("R4",  2'd0, 1, 2'd3, 55, 1, 0, 0);     // else-side only
    issue("R5",  2'd1, 0, 2'd0, 0, 1, 1, 0);      // depth 2
    issue("R5",  2'd1, 0, 2'd0, 0, 1, 2, 0);      // depth 3
    issue("R5",  2'd1, 0, 2'd0, 100, 0, 0, 0);    // depth 4
    issue("R8",  2'd1, 0, 2'd0, 100, 0, 0, 0);    // push on full
    issue("R7",  2'd0, 1, 2'd0, 9, 9, 9, 9);      // single lane active
    issue("R4",  2'd3, 0, 2'd0, 0, 0, 0, 0);
    issue("R4",  2'd3, 0, 2'd0, 0, 0, 0, 0);
    issue("R4",  2'd3, 0, 2'd0, 0, 0, 0, 0);
    issue("R7",  2'd3, 0, 2'd0, 0, 0, 0, 0);      // reconverged, 8 lanes
    issue("R1",  2'd0, 1, 2'd2, 3, 1, -4, 2);
    issue("R6",  2'd1, 0, 2'd0, 0, 0, 5, 0);      // all lanes false
    issue("R6",  2'd0, 1, 2'd1, 77, 1, 3, 0);     // skipped
    issue("R4",  2'd2, 0, 2'd0, 0, 0, 0, 0);
    issue("R1",  2'd3, 1, 2'd0, -1, -1, 1, 0);
    idle();

    do_reset();
    issue("R8",  2'd3, 0, 2'd0, 0, 0, 0, 0);      // pop on empty
    issue("R8",  2'd0, 1, 2'd0, 2, 2, 2, 2);
    do_reset();
    issue("R7",  2'd1, 0, 2'd0, 0, -1, -1, 0);    // only lane 0 true
    issue("R7",  2'd0, 1, 2'd1, 0, 4, 5, 1);
    issue("R7",  2'd2, 1, 2'd0, 8, 1, 8, 1);      // else: lanes 1..7
    issue("R7",  2'd3, 1, 2'd2, 2, 1, 3, 0);
    idle();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule